// File: doc/BRIEF.md
# Dual-Channel Converter Capture Front End

This block sits between an external dual pipelined analog-to-digital converter and the signal-processing logic of a chip. Both converter channels share one sample clock and each presents an 11-bit word on its own bus every cycle. The block latches both buses on the falling clock edge, where the data is stable. On the next rising edge it turns each word into a single signed two's-complement form, whichever coding the converter is currently set to emit. Alongside each word it raises flags for the positive and negative full-scale codes.

The block also drives the converter's power-down, coding-select and per-channel active-low output-enable pins from host control inputs, each one register stage late. A per-channel valid strobe tells downstream logic which samples it can trust. The strobe stays low in these cases:
- while the converter is powered down;
- for a recovery window after power-down is released, plus the pipeline latency;
- for the pipeline latency after reset;
- for a short guard window after the coding select flips or a channel's output is re-enabled;
- while a channel's output is disabled.

Top module: `dual_adc_capture`

## Requirements
- R1: Each channel's bus is sampled on the falling clock edge. The sample appears on the signed output at the next rising edge, so a bus change made after that falling edge does not affect that output.
- R2: When the coding select in use (the registered `adc_fmt`) is 0, the input is offset binary. The output is the input with bit 10 inverted: 1024 gives 0, 0 gives -1024, and 2047 gives +1023.
- R3: When the coding select in use is 1, the input is already two's complement and is passed through unchanged.
- R4: The over-range flag is 1 exactly when the output is +1023, and the under-range flag is 1 exactly when it is -1024. Each flag is registered on the same edge as the sample it qualifies, and the two flags are never 1 together.
- R5: While reset is low, at each rising edge: the outputs go to 0, both valid strobes go low, `adc_pd` and `adc_fmt` go to 0, and both `adc_oe_n` pins go to 1 (buses disabled).
- R6: While `adc_pd` or `host_pd` is 1, both valid strobes are low. After `host_pd` falls they stay low for RECOVER_CYC + LATENCY further cycles.
- R7: A change of `host_fmt_twos` holds both valid strobes low for at least GUARD + LATENCY cycles. A window already longer than that is not shortened.
- R8: Re-enabling one channel's output (host enable going from 0 to 1) holds only that channel's strobe low for GUARD + LATENCY cycles. The other channel's strobe is unaffected.
- R9: `adc_pd`, `adc_fmt` and `adc_oe_n_a`/`adc_oe_n_b` follow `host_pd`, `host_fmt_twos` and the inverted host enables one clock later.
- R10: While a channel's output is disabled its strobe is low, but its samples keep updating every cycle.
- R11: After reset is released the valid strobes stay low for LATENCY cycles, in addition to any enable guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_pd | input | 1 | Host request to power the converter down |
| host_fmt_twos | input | 1 | Host coding select: 1 = two's complement, 0 = offset binary |
| host_oe_a | input | 1 | Host output enable for channel A (active high) |
| host_oe_b | input | 1 | Host output enable for channel B (active high) |
| adc_da | input | 11 | Channel A converter bus, bit 0 LSB |
| adc_db | input | 11 | Channel B converter bus, bit 0 LSB |
| adc_pd | output | 1 | Power-down pin to converter |
| adc_fmt | output | 1 | Coding select pin to converter |
| adc_oe_n_a | output | 1 | Active-low output enable, channel A |
| adc_oe_n_b | output | 1 | Active-low output enable, channel B |
| smp_a | output | 11 | Signed sample, channel A |
| smp_b | output | 11 | Signed sample, channel B |
| vld_a | output | 1 | Sample-valid strobe, channel A |
| vld_b | output | 1 | Sample-valid strobe, channel B |
| ovr_a | output | 1 | Positive full-scale flag, channel A |
| ovr_b | output | 1 | Positive full-scale flag, channel B |
| und_a | output | 1 | Negative full-scale flag, channel A |
| und_b | output | 1 | Negative full-scale flag, channel B |

## Verification
On every cycle the assertions check the following properties:
- a power-down, coding change or re-enable pulls the strobe low on the next cycle;
- the strobe stays low on the cycle power-down is released;
- the converter pins track the host inputs with one cycle of delay;
- the two range flags never rise together.

Window lengths, the bit-10 conversion, falling-edge capture and the independence of the two channels are shown only by the bench scenarios. These are corner codes in both codings, a bus that changes between the falling and rising edges, a single-channel re-enable and a full power-down cycle. All of them are compared every clock against a behavioural model.

// File: rtl/adc_cap_pkg.sv
// Shared types for the dual-channel capture front end.
package adc_cap_pkg;
    localparam int unsigned NCH = 2;

    // Host-side control image, one stage before the converter pins.
    typedef struct packed {
        logic           pd;
        logic           fmt_twos;
        logic [NCH-1:0] oe;
    } host_ctl_t;
endpackage

// File: rtl/adc_ctl_regs.sv
// Control register stage: drives the converter's power-down, coding-select and
// active-low output-enable pins from the host image, one clock late. It also
// raises the disturbance indications the validity trackers need.
// Assumes host inputs are synchronous to clk.
module adc_ctl_regs
    import adc_cap_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  host_ctl_t      host,
    output logic           pd_q,
    output logic           fmt_q,
    output logic [NCH-1:0] oe_n_q,
    output logic           pd_hold,
    output logic           fmt_evt,
    output logic [NCH-1:0] oe_evt
);

    // Register the converter pins; reset leaves both buses disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q   <= 1'b0;
            fmt_q  <= 1'b0;
            oe_n_q <= '1;
        end else begin
            pd_q   <= host.pd;
            fmt_q  <= host.fmt_twos;
            oe_n_q <= ~host.oe;
        end
    end

    // Disturbance indications, valid in the cycle before the pins change.
    always_comb begin
        pd_hold = host.pd | pd_q;
        fmt_evt = host.fmt_twos ^ fmt_q;
        oe_evt  = host.oe & oe_n_q;
    end

    AST_CTL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pd_q == $past(host.pd) && fmt_q == $past(host.fmt_twos)
                          && oe_n_q == ~$past(host.oe))); // R9

endmodule

// File: rtl/adc_valid_tracker.sv
// Per-channel validity tracker: a down-counter that must reach zero before the
// channel's strobe is raised. Power-down reloads the recovery-plus-latency
// window; a coding change or re-enable raises the count to at least the
// guard-plus-latency window; reset loads the pipeline latency.
module adc_valid_tracker #(
    parameter int unsigned LATENCY     = 6,
    parameter int unsigned GUARD       = 8,
    parameter int unsigned RECOVER_CYC = 33000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_hold,
    input  logic disturb,
    input  logic chan_on,
    output logic vld
);
    localparam int unsigned LOAD_PD = RECOVER_CYC + LATENCY;
    localparam int unsigned LOAD_GD = GUARD + LATENCY;
    localparam int unsigned CW      = $clog2(LOAD_PD + LOAD_GD + 1) + 1;
    localparam logic [CW-1:0] K_LAT = CW'(LATENCY);
    localparam logic [CW-1:0] K_PD  = CW'(LOAD_PD);
    localparam logic [CW-1:0] K_GD  = CW'(LOAD_GD);

    logic [CW-1:0] cnt;

    // Load or count down the hold-off window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= K_LAT;
        end else if (pd_hold) begin
            cnt <= K_PD;
        end else if (disturb) begin
            if (cnt < K_GD) cnt <= K_GD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Strobe only with an expired window and an enabled bus.
    always_comb vld = (cnt == '0) && chan_on;

    AST_PD_BLOCKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pd_hold |=> !vld); // R6
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_hold) |-> !vld); // R6
    AST_DISTURB_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        disturb |=> !vld); // R7

endmodule

// File: rtl/adc_lane.sv
// One capture lane: latches the converter bus on the falling edge, converts it
// to two's complement on the next rising edge and flags the full-scale codes.
// Assumes fmt_twos is the coding select currently driven to the converter.
module adc_lane #(
    parameter int unsigned DW = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:0]        raw,
    input  logic                 fmt_twos,
    output logic signed [DW-1:0] smp,
    output logic                 ovr,
    output logic                 und
);
    localparam logic [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] cap;
    logic [DW-1:0] norm;

    // Falling-edge capture; pure data path, so no reset is needed.
    always_ff @(negedge clk) begin
        cap <= raw;
    end

    // Offset binary becomes two's complement by flipping the MSB.
    always_comb norm = fmt_twos ? cap : {~cap[DW-1], cap[DW-2:0]};

    // Register the sample and its range flags together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp <= '0;
            ovr <= 1'b0;
            und <= 1'b0;
        end else begin
            smp <= $signed(norm);
            ovr <= (norm == POS_FS);
            und <= (norm == NEG_FS);
        end
    end

    AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovr && und)); // R4

endmodule

// File: rtl/dual_adc_capture.sv
// Top of the dual-channel capture front end. Contains one control register
// stage and, per channel, a capture lane and a validity tracker.
// Assumes converter buses and host inputs are synchronous to clk.
module dual_adc_capture
    import adc_cap_pkg::*;
#(
    parameter int unsigned DW          = 11,
    parameter int unsigned LATENCY     = 6,
    parameter int unsigned GUARD       = 8,
    parameter int unsigned RECOVER_CYC = 33000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_pd,
    input  logic                 host_fmt_twos,
    input  logic                 host_oe_a,
    input  logic                 host_oe_b,
    input  logic [DW-1:0]        adc_da,
    input  logic [DW-1:0]        adc_db,
    output logic                 adc_pd,
    output logic                 adc_fmt,
    output logic                 adc_oe_n_a,
    output logic                 adc_oe_n_b,
    output logic signed [DW-1:0] smp_a,
    output logic signed [DW-1:0] smp_b,
    output logic                 vld_a,
    output logic                 vld_b,
    output logic                 ovr_a,
    output logic                 ovr_b,
    output logic                 und_a,
    output logic                 und_b
);
    host_ctl_t                    host;
    logic [NCH-1:0]               oe_n;
    logic                         pd_hold;
    logic                         fmt_evt;
    logic [NCH-1:0]               oe_evt;
    logic [NCH-1:0][DW-1:0]       raw;
    logic [NCH-1:0][DW-1:0]       smp;
    logic [NCH-1:0]               vld;
    logic [NCH-1:0]               ovr;
    logic [NCH-1:0]               und;

    // Gather host controls and converter buses into channel-indexed form.
    always_comb begin
        host.pd       = host_pd;
        host.fmt_twos = host_fmt_twos;
        host.oe       = {host_oe_b, host_oe_a};
        raw[0]        = adc_da;
        raw[1]        = adc_db;
    end

    adc_ctl_regs u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .host    (host),
        .pd_q    (adc_pd),
        .fmt_q   (adc_fmt),
        .oe_n_q  (oe_n),
        .pd_hold (pd_hold),
        .fmt_evt (fmt_evt),
        .oe_evt  (oe_evt)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic signed [DW-1:0] smp_s;

        adc_lane #(.DW(DW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (raw[ch]),
            .fmt_twos (adc_fmt),
            .smp      (smp_s),
            .ovr      (ovr[ch]),
            .und      (und[ch])
        );

        adc_valid_tracker #(
            .LATENCY     (LATENCY),
            .GUARD       (GUARD),
            .RECOVER_CYC (RECOVER_CYC)
        ) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .pd_hold (pd_hold),
            .disturb (fmt_evt | oe_evt[ch]),
            .chan_on (~oe_n[ch]),
            .vld     (vld[ch])
        );

        always_comb smp[ch] = smp_s;
    end

    // Spread channel-indexed results onto the named ports.
    always_comb begin
        adc_oe_n_a = oe_n[0];
        adc_oe_n_b = oe_n[1];
        smp_a      = $signed(smp[0]);
        smp_b      = $signed(smp[1]);
        vld_a      = vld[0];
        vld_b      = vld[1];
        ovr_a      = ovr[0];
        ovr_b      = ovr[1];
        und_a      = und[0];
        und_b      = und[1];
    end

    AST_PD_HOLDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        adc_pd |-> (!vld_a && !vld_b)); // R6

endmodule

// File: tb/dual_adc_capture_bench.sv
// Bench: behavioural per-cycle model compared against the design at every
// falling edge, plus scenario checks for capture edge and reset.
module dual_adc_capture_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 6;
    localparam int GRD = 8;
    localparam int REC = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_pd = 1'b0, host_fmt = 1'b0, oe_a = 1'b0, oe_b = 1'b0;
    logic [10:0] da = '0, db = '0;
    logic adc_pd, adc_fmt, adc_oe_n_a, adc_oe_n_b;
    logic signed [10:0] smp_a, smp_b;
    logic vld_a, vld_b, ovr_a, ovr_b, und_a, und_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit hold_data = 1;
    int k = 0;
    string vtag = "R5";

    // Model state.
    logic [10:0] m_cap_a, m_cap_b;
    logic        m_pd = 0, m_fmt = 0;
    logic [1:0]  m_oe = 0;
    int          mcnt[2];
    logic signed [10:0] e_smp[2];
    logic        e_ovr[2], e_und[2];
    string       e_stag[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_adc_capture #(.LATENCY(LAT), .GUARD(GRD), .RECOVER_CYC(REC)) u_dual_adc_capture (
        .clk(clk), .rst_n(rst_n), .host_pd(host_pd), .host_fmt_twos(host_fmt),
        .host_oe_a(oe_a), .host_oe_b(oe_b), .adc_da(da), .adc_db(db),
        .adc_pd(adc_pd), .adc_fmt(adc_fmt), .adc_oe_n_a(adc_oe_n_a), .adc_oe_n_b(adc_oe_n_b),
        .smp_a(smp_a), .smp_b(smp_b), .vld_a(vld_a), .vld_b(vld_b),
        .ovr_a(ovr_a), .ovr_b(ovr_b), .und_a(und_a), .und_b(und_b)
    );

    task automatic chk(input int act, input int exp, input string tag, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model update at each rising edge, from pre-edge values.
    always @(posedge clk) begin
        logic [10:0] cap;
        logic [10:0] v;
        started = 1;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                e_smp[c] = 0; e_ovr[c] = 0; e_und[c] = 0; mcnt[c] = LAT; e_stag[c] = "R5";
            end
            m_pd = 0; m_fmt = 0; m_oe = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                cap = (c == 0) ? m_cap_a : m_cap_b;
                v = m_fmt ? cap : (cap ^ 11'h400);
                e_smp[c] = $signed(v);
                e_ovr[c] = (v == 11'h3FF);
                e_und[c] = (v == 11'h400);
                e_stag[c] = m_fmt ? "R3" : "R2";
                if (host_pd || m_pd) mcnt[c] = REC + LAT;
                else if ((host_fmt != m_fmt) || (((c == 0) ? oe_a : oe_b) && !m_oe[c])) begin
                    if (mcnt[c] < GRD + LAT) mcnt[c] = GRD + LAT;
                end else if (mcnt[c] > 0) mcnt[c]--;
            end
            m_pd = host_pd; m_fmt = host_fmt; m_oe = {oe_b, oe_a};
        end
    end

    // Compare at the falling edge, then take the model's own bus capture.
    always @(negedge clk) begin
        if (started) begin
            chk(smp_a, e_smp[0], e_stag[0], "smp_a");
            chk(smp_b, e_smp[1], e_stag[1], "smp_b");
            chk(ovr_a, e_ovr[0], "R4", "ovr_a");
            chk(und_a, e_und[0], "R4", "und_a");
            chk(ovr_b, e_ovr[1], "R4", "ovr_b");
            chk(und_b, e_und[1], "R4", "und_b");
            chk(vld_a, (mcnt[0] == 0 && m_oe[0] && !m_pd), vtag, "vld_a");
            chk(vld_b, (mcnt[1] == 0 && m_oe[1] && !m_pd), vtag, "vld_b");
            chk(adc_pd, m_pd, "R9", "adc_pd");
            chk(adc_fmt, m_fmt, "R9", "adc_fmt");
            chk(adc_oe_n_a, !m_oe[0], "R9", "adc_oe_n_a");
            chk(adc_oe_n_b, !m_oe[1], "R9", "adc_oe_n_b");
        end
        m_cap_a = da;
        m_cap_b = db;
    end

    // Free-running converter data.
    always @(posedge clk) begin
        #1;
        if (!hold_data) begin
            k++;
            da = 11'((k * 37 + 5) % 2048);
            db = 11'((k * 91 + 700) % 2048);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(4);
        @(negedge clk); #1;
        // R5: reset state at the ports.
        chk(smp_a, 0, "R5", "reset smp_a");
        chk(vld_a || vld_b, 0, "R5", "reset vld");
        chk({adc_oe_n_b, adc_oe_n_a}, 3, "R5", "reset oe_n");
        chk(adc_pd, 0, "R5", "reset pd");
        @(posedge clk); #1;
        rst_n = 1; vtag = "R11";
        oe_a = 1; oe_b = 1; hold_data = 0;
        cyc(25);
        vtag = "R2";
        cyc(30);
        // R4 corners in offset binary.
        hold_data = 1;
        da = 11'd0; db = 11'd2047; cyc(1);
        da = 11'd1024; db = 11'd1023; cyc(1);
        // R1: bus changes after the falling edge must not reach this sample.
        da = 11'd100; db = 11'd200;
        @(negedge clk); #1;
        da = 11'd900; db = 11'd1500;
        @(posedge clk); @(negedge clk); #1;
        chk(smp_a, 100 - 1024, "R1", "falling-edge capture a");
        chk(smp_b, 200 - 1024, "R1", "falling-edge capture b");
        @(posedge clk); @(negedge clk); #1;
        chk(smp_a, 900 - 1024, "R1", "next capture a");
        hold_data = 0;
        cyc(3);
        vtag = "R7";
        host_fmt = 1;
        cyc(4);
        host_fmt = 0;
        cyc(3);
        host_fmt = 1;
        cyc(25);
        vtag = "R3";
        hold_data = 1;
        da = 11'h3FF; db = 11'h400; cyc(1);
        da = 11'h000; db = 11'h7FF; cyc(1);
        hold_data = 0;
        cyc(5);
        vtag = "R10";
        oe_a = 0;
        cyc(12);
        vtag = "R8";
        oe_a = 1;
        cyc(25);
        vtag = "R6";
        host_pd = 1;
        cyc(6);
        host_pd = 0;
        cyc(REC + LAT + 12);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule